// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sorts every CPU-side address into one of eight programmed windows: a main memory bank, four memory-module banks, two outbound bus-memory windows and one outbound bus-I/O window. It also sorts every bus-side address into one of two inbound target windows that lead back into CPU space. Each window is described by one 32-bit configuration word, written through a small register port. The word holds the enable bit, the base, the size and, for the bus windows, a local-address field.

The result is registered. It gives a one-hot window hit, a no-hit flag and a translated address. For the outbound bus windows, the translation replaces the high address bits with the programmed local field. The inbound side gives the same three results for its own address.

Memory banks encode their size as a run of clear bits, each of which doubles a minimum size. Bus windows encode their size as a 7-bit mask that is shifted into place and inverted. When windows overlap, a fixed order decides which one hits.

Top module: `addr_window_decoder`

## Requirements
- R1: Config word 0 is the main bank. It is enabled by bit 3, and its base is bits 27:22 placed at address bits 27:22. Its size is 4 MB when bit 14 is set, 8 MB when bit 14 is clear and bit 15 is set, and 16 MB when both are clear.
- R2: Config words 1 to 4 are module banks 1 to 4. Each is enabled by bit 3 and takes its base from bits 27:21 at address bits 27:21. The size starts at 2 MB and doubles for each clear bit, scanning from bit 13 up to bit 17 and stopping at the first set bit, so the largest size is 64 MB.
- R3: Config words 5, 6 and 7 are bus-memory window 1, bus-memory window 2 and the bus-I/O window. Each is enabled by bit 12 and takes its base from bits 31:24. Its last address is the base ORed with the inverse of (bit 31 set ORed with mask bits 19:13 shifted left by 24).
- R4: On a bus-window hit, out_addr is config bits 7:0 in address bits 31:24, ORed with (address minus base). On a bank hit or on no hit, out_addr is zero.
- R5: Config words 8 and 9 are inbound target windows 1 and 2. Each is enabled by bit 12 and takes its base from bits 31:21. Its last address is the base ORed with the inverse of (bits 31:28 set ORed with mask bits 19:13 shifted left by 21).
- R6: On a target hit, tgt_addr is config bits 10:0 in address bits 31:21, ORed with (bus address minus base). Otherwise tgt_addr is zero.
- R7: win_hit bit 0 is the main bank, bits 1 to 4 are module banks 1 to 4, and bits 5, 6 and 7 are the three bus windows. On overlap, the lowest index wins, so at most one bit is set. win_miss is high exactly when no bit is set.
- R8: tgt_hit bit 0 is target window 1 and bit 1 is target window 2. Window 1 wins on overlap. tgt_miss is high exactly when neither bit is set.
- R9: An address applied before a clock edge shows its result after that edge. A config write taken at an edge is first used by the decode registered at the following edge.
- R10: A write with cfg_sel of 10 or more changes no window.
- R11: Reset clears every config word, sets win_miss and tgt_miss, and zeroes the hits and both addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | config write strobe |
| cfg_sel | input | 4 | config word index |
| cfg_wdata | input | 32 | config write data |
| cpu_addr | input | 32 | CPU-side address to decode |
| bus_addr | input | 32 | bus-side address to decode |
| win_hit | output | 8 | one-hot outbound window hit |
| win_miss | output | 1 | no outbound window hit |
| out_addr | output | 32 | translated bus address |
| tgt_hit | output | 2 | one-hot inbound window hit |
| tgt_miss | output | 1 | no inbound window hit |
| tgt_addr | output | 32 | translated CPU address |

## Verification
The assertions check the following on every cycle:
- the hit vectors stay one-hot or empty, and each miss flag agrees with its vector;
- out_addr stays zero on a bank hit;
- a main-bank hit never occurs without the enable bit;
- a write to an index outside the window set leaves every config word unchanged.

The bench scenarios are needed for the following:
- the window sizes encoded by clear-bit runs and by masks, including the first address past each end;
- the overlap order;
- the translated addresses;
- the one-cycle lag after a config write.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        WK_MAIN   = 2'd0,
        WK_SIMM   = 2'd1,
        WK_MASTER = 2'd2,
        WK_TARGET = 2'd3
    } win_kind_e;

    // size = min_size doubled once per clear bit from first_bit upward, stop at first set bit
    function automatic logic [ADDR_W-1:0] run_size(input logic [ADDR_W-1:0] cfg,
                                                   input int first_bit,
                                                   input int nbits,
                                                   input logic [ADDR_W-1:0] min_size);
        logic [ADDR_W-1:0] sz;
        logic              halt;
        sz   = min_size;
        halt = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < nbits && !halt) begin
                if (cfg[first_bit + i]) halt = 1'b1;
                else                    sz   = sz << 1;
            end
        end
        return sz;
    endfunction
endpackage

// File: rtl/awd_cfg_regs.sv
module awd_cfg_regs #(
    parameter int NUM_CFG = 10,
    parameter int SEL_W   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we_i,
    input  logic [SEL_W-1:0]                       sel_i,
    input  logic [awd_pkg::ADDR_W-1:0]             wdata_i,
    output logic [NUM_CFG-1:0][awd_pkg::ADDR_W-1:0] cfg_o
);
    logic [NUM_CFG-1:0][awd_pkg::ADDR_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (we_i && (int'(sel_i) == i)) cfg_d[i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    assert_oob_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (int'(sel_i) >= NUM_CFG)) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/awd_window.sv
module awd_window #(
    parameter awd_pkg::win_kind_e KIND = awd_pkg::WK_MAIN
) (
    input  logic [awd_pkg::ADDR_W-1:0] cfg_i,
    input  logic [awd_pkg::ADDR_W-1:0] addr_i,
    output logic                       hit_o,
    output logic [awd_pkg::ADDR_W-1:0] xlat_o
);
    import awd_pkg::*;

    logic              en;
    logic [ADDR_W-1:0] base, last, lbase;

    generate
        if (KIND == WK_MAIN) begin : g_main
            always_comb begin
                en    = cfg_i[3];
                base  = {4'b0, cfg_i[27:22], 22'b0};
                last  = base + (run_size(cfg_i, 14, 2, 32'h0040_0000) - 32'd1);
                lbase = '0;
            end
        end else if (KIND == WK_SIMM) begin : g_simm
            always_comb begin
                en    = cfg_i[3];
                base  = {4'b0, cfg_i[27:21], 21'b0};
                last  = base + (run_size(cfg_i, 13, 5, 32'h0020_0000) - 32'd1);
                lbase = '0;
            end
        end else if (KIND == WK_MASTER) begin : g_master
            always_comb begin
                en    = cfg_i[12];
                base  = {cfg_i[31:24], 24'b0};
                last  = base | {1'b0, ~cfg_i[19:13], 24'hFF_FFFF};
                lbase = {cfg_i[7:0], 24'b0};
            end
        end else begin : g_target
            always_comb begin
                en    = cfg_i[12];
                base  = {cfg_i[31:21], 21'b0};
                last  = base | {4'b0, ~cfg_i[19:13], 21'h1F_FFFF};
                lbase = {cfg_i[10:0], 21'b0};
            end
        end
    endgenerate

    always_comb begin
        hit_o  = en && (addr_i >= base) && (addr_i <= last);
        xlat_o = hit_o ? (lbase | (addr_i - base)) : '0;
    end
endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
    parameter int NUM_SIMM   = 4,
    parameter int NUM_MASTER = 3,
    parameter int NUM_TGT    = 2,
    parameter int SEL_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SEL_W-1:0]             cfg_sel,
    input  logic [31:0]                  cfg_wdata,
    input  logic [31:0]                  cpu_addr,
    input  logic [31:0]                  bus_addr,
    output logic [1+NUM_SIMM+NUM_MASTER-1:0] win_hit,
    output logic                         win_miss,
    output logic [31:0]                  out_addr,
    output logic [NUM_TGT-1:0]           tgt_hit,
    output logic                         tgt_miss,
    output logic [31:0]                  tgt_addr
);
    import awd_pkg::*;

    localparam int NUM_OUT = 1 + NUM_SIMM + NUM_MASTER;
    localparam int NUM_CFG = NUM_OUT + NUM_TGT;
    localparam int MW_LO   = 1 + NUM_SIMM;

    typedef struct packed {
        logic [NUM_OUT-1:0] hit;
        logic               miss;
        logic [ADDR_W-1:0]  oaddr;
        logic [NUM_TGT-1:0] thit;
        logic               tmiss;
        logic [ADDR_W-1:0]  taddr;
    } dec_t;

    localparam dec_t DEC_RST = '{hit: '0, miss: 1'b1, oaddr: '0,
                                 thit: '0, tmiss: 1'b1, taddr: '0};

    logic [NUM_CFG-1:0][ADDR_W-1:0] cfg_vec;
    logic [NUM_CFG-1:0]             raw_hit;
    logic [NUM_CFG-1:0][ADDR_W-1:0] raw_xlat;
    logic [NUM_OUT-1:0]             out_grant;
    logic                           out_any;
    logic [NUM_TGT-1:0]             tgt_grant;
    logic                           tgt_any;
    dec_t                           dec_d, dec_q;

    awd_cfg_regs #(.NUM_CFG(NUM_CFG), .SEL_W(SEL_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg_vec)
    );

    generate
        for (genvar g = 0; g < NUM_CFG; g++) begin : g_win
            localparam win_kind_e K = (g == 0)       ? WK_MAIN   :
                                      (g < MW_LO)    ? WK_SIMM   :
                                      (g < NUM_OUT)  ? WK_MASTER : WK_TARGET;
            if (g < NUM_OUT) begin : g_cpu
                awd_window #(.KIND(K)) u_win (
                    .cfg_i  (cfg_vec[g]),
                    .addr_i (cpu_addr),
                    .hit_o  (raw_hit[g]),
                    .xlat_o (raw_xlat[g])
                );
            end else begin : g_bus
                awd_window #(.KIND(K)) u_win (
                    .cfg_i  (cfg_vec[g]),
                    .addr_i (bus_addr),
                    .hit_o  (raw_hit[g]),
                    .xlat_o (raw_xlat[g])
                );
            end
        end
    endgenerate

    awd_pick #(.N(NUM_OUT)) u_pick_out (
        .req_i   (raw_hit[NUM_OUT-1:0]),
        .grant_o (out_grant),
        .any_o   (out_any)
    );

    awd_pick #(.N(NUM_TGT)) u_pick_tgt (
        .req_i   (raw_hit[NUM_CFG-1:NUM_OUT]),
        .grant_o (tgt_grant),
        .any_o   (tgt_any)
    );

    always_comb begin
        dec_d       = dec_q;
        dec_d.hit   = out_grant;
        dec_d.miss  = !out_any;
        dec_d.oaddr = '0;
        for (int i = MW_LO; i < NUM_OUT; i++) begin
            if (out_grant[i]) dec_d.oaddr = dec_d.oaddr | raw_xlat[i];
        end
        dec_d.thit  = tgt_grant;
        dec_d.tmiss = !tgt_any;
        dec_d.taddr = '0;
        for (int j = 0; j < NUM_TGT; j++) begin
            if (tgt_grant[j]) dec_d.taddr = dec_d.taddr | raw_xlat[NUM_OUT + j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= DEC_RST;
        else        dec_q <= dec_d;
    end

    assign win_hit  = dec_q.hit;
    assign win_miss = dec_q.miss;
    assign out_addr = dec_q.oaddr;
    assign tgt_hit  = dec_q.thit;
    assign tgt_miss = dec_q.tmiss;
    assign tgt_addr = dec_q.taddr;

    assert_hit_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_q.hit));
    assert_miss_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.miss == (dec_q.hit == '0));
    assert_tgt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_q.thit) && (dec_q.tmiss == (dec_q.thit == '0)));
    assert_bank_no_xlat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|dec_q.hit[MW_LO-1:0]) |-> (dec_q.oaddr == '0));
    assert_main_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.hit[0] |-> $past(cfg_vec[0][3]));
endmodule

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  win_hit;
    logic        win_miss;
    logic [31:0] out_addr;
    logic [1:0]  tgt_hit;
    logic        tgt_miss;
    logic [31:0] tgt_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] mir [10];

    always #10 clk = ~clk;

    addr_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .bus_addr(bus_addr),
        .win_hit(win_hit), .win_miss(win_miss), .out_addr(out_addr),
        .tgt_hit(tgt_hit), .tgt_miss(tgt_miss), .tgt_addr(tgt_addr)
    );

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%08h exp=%08h", rq, got, exp);
        end
    endtask

    function automatic void win_eval(input int idx, input logic [31:0] c, input logic [31:0] a,
                                     output logic h, output logic [31:0] x);
        logic [31:0] b, l, lb;
        logic        e;
        int          n;
        lb = '0;
        n  = 0;
        if (idx == 0) begin
            e = c[3]; b = c & 32'h0fc0_0000;
            if (!c[14]) begin n = 1; if (!c[15]) n = 2; end
            l = b + ((32'h0040_0000 << n) - 1);
        end else if (idx <= 4) begin
            e = c[3]; b = c & 32'h0fe0_0000;
            while (n < 5 && !c[13+n]) n++;
            l = b + ((32'h0020_0000 << n) - 1);
        end else if (idx <= 7) begin
            e = c[12]; b = c & 32'hff00_0000;
            l = b | ~(32'h8000_0000 | ({25'b0, c[19:13]} << 24));
            lb = {c[7:0], 24'h0};
        end else begin
            e = c[12]; b = c & 32'hffe0_0000;
            l = b | ~(32'hf000_0000 | ({25'b0, c[19:13]} << 21));
            lb = {c[10:0], 21'h0};
        end
        h = e && a >= b && a <= l;
        x = h ? (lb | (a - b)) : 32'h0;
    endfunction

    task automatic compare(input string rq, input logic [31:0] ca, input logic [31:0] ba);
        logic [7:0]  eh;
        logic [31:0] eo, et, x;
        logic [1:0]  th;
        logic        h;
        eh = '0; eo = '0; th = '0; et = '0;
        for (int i = 0; i < 8; i++) begin
            win_eval(i, mir[i], ca, h, x);
            if (h && eh == 0) begin eh[i] = 1'b1; if (i >= 5) eo = x; end
        end
        for (int i = 0; i < 2; i++) begin
            win_eval(8 + i, mir[8+i], ba, h, x);
            if (h && th == 0) begin th[i] = 1'b1; et = x; end
        end
        chk({rq, " win_hit"},  {24'b0, win_hit}, {24'b0, eh});
        chk({rq, " win_miss"}, {31'b0, win_miss}, {31'b0, eh == 0});
        chk({rq, " out_addr"}, out_addr, eo);
        chk({rq, " tgt_hit"},  {30'b0, tgt_hit}, {30'b0, th});
        chk({rq, " tgt_miss"}, {31'b0, tgt_miss}, {31'b0, th == 0});
        chk({rq, " tgt_addr"}, tgt_addr, et);
    endtask

    task automatic wcfg(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < 10) mir[s] = d;
    endtask

    task automatic probe(input string rq, input logic [31:0] ca, input logic [31:0] ba);
        @(negedge clk);
        cpu_addr = ca; bus_addr = ba;
        @(negedge clk);
        compare(rq, ca, ba);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 10; i++) mir[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 win_hit", {24'b0, win_hit}, 32'h0);
        chk("R11 win_miss", {31'b0, win_miss}, 32'h1);
        chk("R11 out_addr", out_addr, 32'h0);
        chk("R11 tgt_miss", {31'b0, tgt_miss}, 32'h1);
        chk("R11 tgt_addr", tgt_addr, 32'h0);

        // R1 main bank sizes
        wcfg(0, 32'h0040_0000 | 32'h8 | (1 << 14));
        probe("R1 4MB last", 32'h007F_FFFF, 0);
        chk("R1 4MB hit", {24'b0, win_hit}, 32'h1);
        probe("R1 4MB past", 32'h0080_0000, 0);
        chk("R1 4MB past miss", {31'b0, win_miss}, 32'h1);
        wcfg(0, 32'h0040_0000 | 32'h8 | (1 << 15));
        probe("R1 8MB last", 32'h00BF_FFFF, 0);
        probe("R1 8MB past", 32'h00C0_0000, 0);
        wcfg(0, 32'h0040_0000 | 32'h8);
        probe("R1 16MB last", 32'h013F_FFFF, 0);
        chk("R1 16MB hit", {24'b0, win_hit}, 32'h1);
        probe("R1 16MB past", 32'h0140_0000, 0);

        // R2 module bank sizes, R7 overlap order
        wcfg(1, 32'h0200_0000 | 32'h8);
        probe("R2 64MB last", 32'h05FF_FFFF, 0);
        chk("R2 64MB hit", {24'b0, win_hit}, 32'h2);
        probe("R2 64MB past", 32'h0600_0000, 0);
        wcfg(2, 32'h0060_0000 | 32'h8 | (1 << 13));
        probe("R7 main over bank2", 32'h0060_0000, 0);
        chk("R7 main wins", {24'b0, win_hit}, 32'h1);
        wcfg(0, 32'h0);
        probe("R2 2MB hit", 32'h007F_FFFF, 0);
        chk("R2 bank2 hit", {24'b0, win_hit}, 32'h4);
        probe("R2 2MB past", 32'h0080_0000, 0);

        // R3/R4 bus windows
        wcfg(5, 32'h4000_0000 | (32'h7F << 13) | (1 << 12) | 32'h12);
        probe("R4 mw1 xlat", 32'h40AB_CDEF, 0);
        chk("R4 mw1 out_addr", out_addr, 32'h12AB_CDEF);
        probe("R3 mw1 past", 32'h4100_0000, 0);
        wcfg(5, 32'h4000_0000 | (32'h7E << 13) | (1 << 12) | 32'h12);
        probe("R3 mw1 32MB", 32'h4100_0004, 0);
        chk("R3 mw1 32MB hit", {24'b0, win_hit}, 32'h20);
        wcfg(6, 32'h8000_0000 | (32'h7F << 13) | (1 << 12) | 32'h01);
        wcfg(7, 32'h8000_0000 | (32'h7F << 13) | (1 << 12) | 32'h02);
        probe("R7 mw2 over io", 32'h8000_0010, 0);
        chk("R7 mw2 wins", {24'b0, win_hit}, 32'h40);
        wcfg(6, 32'h8000_0000 | (32'h7F << 13) | 32'h01);
        probe("R3 mw2 disabled io hit", 32'h8000_0010, 0);
        chk("R4 io xlat", out_addr, 32'h0200_0010);

        // R5/R6/R8 target windows
        wcfg(8, 32'hA000_0000 | (32'h7F << 13) | (1 << 12) | 32'h003);
        probe("R6 tgt1 xlat", 0, 32'hA001_2344);
        chk("R6 tgt1 addr", tgt_addr, 32'h0061_2344);
        probe("R5 tgt1 past", 0, 32'hA020_0000);
        chk("R5 tgt1 past miss", {31'b0, tgt_miss}, 32'h1);
        wcfg(9, 32'hA000_0000 | (32'h7E << 13) | (1 << 12) | 32'h005);
        probe("R8 tgt1 over tgt2", 0, 32'hA000_0100);
        chk("R8 tgt1 wins", {30'b0, tgt_hit}, 32'h1);
        probe("R5 tgt2 4MB", 0, 32'hA030_0000);
        chk("R5 tgt2 hit", {30'b0, tgt_hit}, 32'h2);

        // R10 out-of-range index
        wcfg(4'd12, 32'hFFFF_FFFF);
        wcfg(4'd15, 32'h0000_0008);
        probe("R10 after oob write", 32'h40AB_CDEF, 32'hA001_2344);
        chk("R10 mw1 unchanged", out_addr, 32'h12AB_CDEF);

        // R9 write lag
        @(negedge clk);
        cpu_addr = 32'h7000_0040;
        cfg_we = 1'b1; cfg_sel = 4'd5;
        cfg_wdata = 32'h7000_0000 | (32'h7F << 13) | (1 << 12);
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R9 old config at write edge", {31'b0, win_miss}, 32'h1);
        mir[5] = cfg_wdata;
        @(negedge clk);
        chk("R9 new config next edge", {24'b0, win_hit}, 32'h20);
        chk("R9 xlat next edge", out_addr, 32'h0000_0040);

        // random mix R1..R8
        for (int it = 0; it < 400; it++) begin
            logic [3:0]  s;
            logic [31:0] d;
            int          k;
            logic [31:0] b, ca, ba;
            s = 4'($urandom_range(0, 11));
            d = $urandom;
            if ($urandom_range(0, 3) != 0) d = d | 32'h0000_1008;
            wcfg(s, d);
            k = $urandom_range(0, 9);
            case (k)
                0:       b = mir[k] & 32'h0fc0_0000;
                1, 2, 3, 4: b = mir[k] & 32'h0fe0_0000;
                5, 6, 7: b = mir[k] & 32'hff00_0000;
                default: b = mir[k] & 32'hffe0_0000;
            endcase
            ca = ($urandom_range(0, 1) == 0) ? $urandom : b + ($urandom & 32'h03FF_FFFF);
            ba = b + ($urandom & 32'h007F_FFFF);
            probe("R7 random", ca, ba);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 got=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule